// File: doc/BRIEF.md
# Block-Write Payload Packetizer

This block sits on the host side of a byte-wide SPI link and sends the payload of a block write once the command for that write has been accepted. A transfer starts with a one-cycle start pulse. The pulse carries the total byte count and a flag that says whether CRC trailers are sent. Payload bytes then arrive on a valid/ready byte stream. The block cuts them into packets of at most `MAX_PKT` bytes.

Every packet opens with a token byte. The upper nibble of the token is all ones. The low two bits of the token give the packet's place in the sequence. When CRC is enabled, each packet's data is followed by two zero bytes. The block reads no response from the peripheral between packets: the token of the next packet is the very next byte offered. A count too small for a block transfer is refused without sending anything. A one-cycle pulse marks the acceptance of the final byte of a transfer.

Top module: `blkw_packetizer`

## Requirements
- R1: A transfer whose length is at most `MAX_PKT` (default 8192) is sent as one packet. Its token is 0xF3, which is 0xF0 with order code 3 in bits [1:0].
- R2: A longer transfer uses token 0xF1 (order code 1) for its first packet and 0xF2 (order code 2) for every later full-size packet. The packet that ends the transfer uses 0xF3.
- R3: Each packet carries min(remaining, `MAX_PKT`) payload bytes right after its token. The bytes are passed through unchanged and in arrival order.
- R4: When `crc_en_i` is sampled high at start, two 0x00 bytes follow each packet's data. When it is sampled low, no trailer bytes are sent.
- R5: Between the final byte of one packet (data or trailer) and the next token, `tx_valid_o` does not drop. No response phase is inserted.
- R6: A start with `len_i` below 5, including 0, raises `err_o` for one cycle in the cycle after the start. In that case no byte is offered and no payload byte is accepted.
- R7: `done_o` pulses for exactly one cycle, in the cycle after the final byte of the last packet is accepted by `tx_ready_i`.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, a token or trailer byte is held stable. `in_ready_o` is never high unless `tx_ready_i` is high.
- R9: A start pulse that arrives while a transfer is in progress is ignored. It changes no output byte and raises no `err_o`.
- R10: After reset, `tx_valid_o`, `in_ready_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse for a transfer |
| len_i | input | 24 | Total payload byte count, sampled with start |
| crc_en_i | input | 1 | Send two trailer bytes per packet, sampled with start |
| in_valid_i | input | 1 | Payload byte valid |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Payload byte accepted this cycle when valid is high |
| tx_valid_o | output | 1 | Byte offered to the SPI transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | SPI transmitter takes the byte this cycle |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Rejected-length pulse |

## Verification
The packetizer is exercised with several lengths, and each length separates a different part of the behaviour:
- Length 5 is the smallest accepted size.
- Length 100, with trailers, separates the CRC path from the plain path.
- Length 8192 tests the boundary where a single 0xF3 packet must still be chosen.
- Length 8193 must give an 0xF1 packet followed by a one-byte 0xF3 packet.
- Length 16385 is the only one of these lengths that exposes the 0xF2 middle token.

Random stalls on both the payload side and the SPI side check that bytes keep their order and that the token and trailer bytes are held steady. Lengths 0, 3 and 4 confirm the reject pulse and that nothing moves. A start pulse sent in the middle of a transfer must leave the byte stream unchanged.

// File: rtl/blkw_pkg.sv
package blkw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOKEN,
    ST_DATA,
    ST_TRL0,
    ST_TRL1
  } blkw_state_e;

  localparam logic [1:0] ORD_FIRST = 2'd1;
  localparam logic [1:0] ORD_NEXT  = 2'd2;
  localparam logic [1:0] ORD_LAST  = 2'd3;

  localparam logic [7:0] TOKEN_BASE = 8'hF0;
  localparam logic [7:0] TRAILER    = 8'h00;

  function automatic logic [7:0] token_byte(input logic [1:0] ord);
    return TOKEN_BASE | {6'd0, ord};
  endfunction

endpackage

// File: rtl/blkw_order_plan.sv
module blkw_order_plan #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic [LEN_W-1:0] remain_i,
  input  logic             first_i,
  output logic [1:0]       order_o,
  output logic [PKT_W-1:0] pkt_len_o
);
  import blkw_pkg::*;

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PKT);
  localparam logic [PKT_W-1:0] MAX_P = PKT_W'(MAX_PKT);

  logic fits;

  assign fits = (remain_i <= MAX_L);

  always_comb begin
    if (fits) begin
      order_o   = ORD_LAST;
      pkt_len_o = remain_i[PKT_W-1:0];
    end else begin
      order_o   = first_i ? ORD_FIRST : ORD_NEXT;
      pkt_len_o = MAX_P;
    end
  end

endmodule

// File: rtl/blkw_seq.sv
module blkw_seq #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 5,
  parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic                  crc_en_i,
  input  logic                  tx_fire_i,
  input  logic [PKT_W-1:0]      plan_len_i,
  output blkw_pkg::blkw_state_e state_o,
  output logic [LEN_W-1:0]      remain_o,
  output logic                  first_o,
  output logic                  done_o,
  output logic                  err_o
);
  import blkw_pkg::*;

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [PKT_W-1:0] ONE_P = PKT_W'(1);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  blkw_state_e      state_q;
  logic [LEN_W-1:0] remain_q;
  logic [PKT_W-1:0] pkt_left_q;
  logic             first_q, crc_q, done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      remain_q   <= '0;
      pkt_left_q <= '0;
      first_q    <= 1'b0;
      crc_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (len_i < MIN_L) begin
              err_q <= 1'b1;
            end else begin
              remain_q <= len_i;
              first_q  <= 1'b1;
              crc_q    <= crc_en_i;
              state_q  <= ST_TOKEN;
            end
          end
        end
        ST_TOKEN: begin
          if (tx_fire_i) begin
            pkt_left_q <= plan_len_i;
            first_q    <= 1'b0;
            state_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tx_fire_i) begin
            remain_q   <= remain_q - ONE_L;
            pkt_left_q <= pkt_left_q - ONE_P;
            if (pkt_left_q == ONE_P) begin
              if (crc_q) begin
                state_q <= ST_TRL0;
              end else if (remain_q == ONE_L) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_TOKEN;
              end
            end
          end
        end
        ST_TRL0: begin
          if (tx_fire_i) state_q <= ST_TRL1;
        end
        ST_TRL1: begin
          if (tx_fire_i) begin
            if (remain_q == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_TOKEN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign remain_o = remain_q;
  assign first_o  = first_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R3: a packet never holds more than the maximum payload
  p_pkt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (pkt_left_q != '0 && pkt_left_q <= PKT_W'(MAX_PKT)));

  // R3: data phase only entered with payload left
  p_remain_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (remain_q != '0));

  // R7: done is a single-cycle pulse
  p_done_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R9: start while busy leaves the state untouched by err
  p_busy_noerr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> !err_q);

endmodule

// File: rtl/blkw_tx_mux.sv
module blkw_tx_mux (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  blkw_pkg::blkw_state_e state_i,
  input  logic [1:0]            order_i,
  input  logic                  in_valid_i,
  input  logic [7:0]            in_data_i,
  input  logic                  tx_ready_i,
  output logic                  in_ready_o,
  output logic                  tx_valid_o,
  output logic [7:0]            tx_data_o,
  output logic                  tx_fire_o
);
  import blkw_pkg::*;

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = TRAILER;
    in_ready_o = 1'b0;
    unique case (state_i)
      ST_TOKEN: begin
        tx_valid_o = 1'b1;
        tx_data_o  = token_byte(order_i);
      end
      ST_DATA: begin
        tx_valid_o = in_valid_i;
        tx_data_o  = in_data_i;
        in_ready_o = tx_ready_i;
      end
      ST_TRL0, ST_TRL1: begin
        tx_valid_o = 1'b1;
        tx_data_o  = TRAILER;
      end
      default: ;
    endcase
  end

  assign tx_fire_o = tx_valid_o & tx_ready_i;

  // R8: generated bytes held while stalled
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && state_i != ST_DATA) |=>
      (tx_valid_o && $stable(tx_data_o)));

  // R8: payload only taken when the link takes it
  p_ready_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> tx_ready_i);

endmodule

// File: rtl/blkw_packetizer.sv
module blkw_packetizer #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             crc_en_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  output logic             done_o,
  output logic             err_o
);
  import blkw_pkg::*;

  localparam int PKT_W = $clog2(MAX_PKT + 1);

  blkw_state_e      state;
  logic [LEN_W-1:0] remain;
  logic             first;
  logic [1:0]       order;
  logic [PKT_W-1:0] plan_len;
  logic             tx_fire;

  blkw_order_plan #(
    .LEN_W  (LEN_W),
    .MAX_PKT(MAX_PKT),
    .PKT_W  (PKT_W)
  ) u_plan (
    .remain_i (remain),
    .first_i  (first),
    .order_o  (order),
    .pkt_len_o(plan_len)
  );

  blkw_seq #(
    .LEN_W  (LEN_W),
    .MAX_PKT(MAX_PKT),
    .MIN_LEN(MIN_LEN),
    .PKT_W  (PKT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .len_i     (len_i),
    .crc_en_i  (crc_en_i),
    .tx_fire_i (tx_fire),
    .plan_len_i(plan_len),
    .state_o   (state),
    .remain_o  (remain),
    .first_o   (first),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  blkw_tx_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .order_i   (order),
    .in_valid_i(in_valid_i),
    .in_data_i (in_data_i),
    .tx_ready_i(tx_ready_i),
    .in_ready_o(in_ready_o),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .tx_fire_o (tx_fire)
  );

  // R1/R2: every token carries the all-ones nibble and a nonzero order code
  p_token_form_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TOKEN) |-> (tx_data_o[7:4] == 4'hF && tx_data_o[1:0] != 2'b00));

  // R6: a reject pulse comes with a silent link
  p_err_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!tx_valid_o && !in_ready_o));

endmodule

// File: tb/tb_blkw_packetizer.sv
`timescale 1ns/1ps
module tb_blkw_packetizer;

  localparam int MAXP = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] len = '0;
  logic        crc_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        done;
  logic        err;

  always #10 clk = ~clk;

  blkw_packetizer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .crc_en_i(crc_en),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .done_o(done), .err_o(err)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         gap_q[$];

  int cur_len = 0, cur_seed = 0, src_idx = 0;
  bit src_active = 0;
  bit held = 0;
  int err_seen = 0;

  function automatic logic [7:0] pay(int i, int seed);
    return 8'((i * 7) + (seed * 13) + (i >> 8));
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: %s got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
    gap_q.push_back(1'b0);
  endtask

  task automatic build_expected(int n_total, bit crc, int seed);
    int rem = n_total;
    int idx = 0;
    bit first = 1;
    while (rem > 0) begin
      int n;
      logic [1:0] ord;
      n = (rem <= MAXP) ? rem : MAXP;
      ord = (rem <= MAXP) ? 2'd3 : (first ? 2'd1 : 2'd2);
      push(8'hF0 | {6'd0, ord}, (ord == 2'd3 && first) ? "R1" : "R2");
      for (int i = 0; i < n; i++) push(pay(idx + i, seed), "R3");
      if (crc) begin
        push(8'h00, "R4");
        push(8'h00, "R4");
      end
      rem -= n;
      idx += n;
      first = 0;
      if (rem > 0) gap_q[gap_q.size() - 1] = 1'b1;
    end
  endtask

  // payload source
  initial begin
    forever begin
      @(negedge clk);
      if (src_active && src_idx < cur_len) begin
        if (!held) held = ($urandom % 4) != 0;
        in_valid = held;
        in_data  = pay(src_idx, cur_seed);
      end else begin
        held = 0;
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        src_idx++;
        held = 0;
      end
    end
  end

  // link side: random stalls and scoreboard monitor
  initial begin
    bit need_valid = 0;
    bit done_due = 0;
    forever begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      #2;
      if (rst_n) begin
        if (err) err_seen++;
        if (done || done_due)
          check(done == done_due, "R7", "done_o", done, done_due);
        done_due = 0;
        if (need_valid) begin
          check(tx_valid == 1'b1, "R5", "tx_valid_o between packets", tx_valid, 1);
          need_valid = 0;
        end
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6/R9", "unexpected byte", tx_data, 0);
          end else begin
            logic [7:0] e;
            string t;
            bit g;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = gap_q.pop_front();
            check(tx_data == e, t, "tx byte", tx_data, e);
            need_valid = g;
            if (exp_q.size() == 0) done_due = 1;
          end
        end
      end
    end
  end

  task automatic run_xfer(int n, bit crc, int seed, bit poke);
    int errs_before;
    build_expected(n, crc, seed);
    cur_len = n; cur_seed = seed; src_idx = 0; src_active = 1;
    errs_before = err_seen;
    @(negedge clk);
    start = 1'b1; len = 24'(n); crc_en = crc;
    @(negedge clk);
    start = 1'b0; crc_en = 1'b0; len = '0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; len = 24'd3; crc_en = ~crc;
      @(negedge clk);
      start = 1'b0; len = '0; crc_en = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1; len = 24'd50;
      @(negedge clk);
      start = 1'b0; len = '0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    src_active = 0;
    check(src_idx == n, "R3", "payload bytes consumed", src_idx, n);
    if (poke) check(err_seen == errs_before, "R9", "err pulses while busy", err_seen, errs_before);
  endtask

  task automatic run_bad(int n);
    cur_len = 10; cur_seed = 1; src_idx = 0; src_active = 1;
    @(negedge clk);
    start = 1'b1; len = 24'(n); crc_en = 1'b1;
    @(negedge clk);
    start = 1'b0; crc_en = 1'b0; len = '0;
    #3;
    check(err == 1'b1, "R6", "err_o after short start", err, 1);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      #3;
      check(!tx_valid && !in_ready, "R6", "link activity after reject",
            {tx_valid, in_ready}, 0);
    end
    check(src_idx == 0, "R6", "payload consumed after reject", src_idx, 0);
    src_active = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not complete got 0 exp 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(!tx_valid && !in_ready && !done && !err, "R10", "outputs in reset",
          {tx_valid, in_ready, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check(!tx_valid && !in_ready && !done && !err, "R10", "outputs after reset",
          {tx_valid, in_ready, done, err}, 0);

    run_xfer(5, 1'b0, 3, 1'b0);        // R1 smallest accepted
    run_xfer(100, 1'b1, 5, 1'b0);      // R4 trailers
    run_xfer(MAXP, 1'b1, 7, 1'b0);     // R1 boundary single packet
    run_xfer(MAXP + 1, 1'b0, 9, 1'b1); // R2 first+last, R9 start while busy
    run_xfer(2 * MAXP + 1, 1'b1, 11, 1'b0); // R2 middle token, R5
    run_bad(0);                        // R6
    run_bad(3);
    run_bad(4);
    run_xfer(6, 1'b1, 2, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

endmodule